// File: doc/BRIEF.md
# Crosspoint Control-Pulse Generator

This block is the hardwired sequencer of a small word-serial processor. It runs a twelve-step time counter that spans one memory cycle. It also holds the subinstruction that owns the current cycle. For every pairing of subinstruction and time step it produces the datapath control pulses. Register moves are expressed as a read pulse on the source register plus a write pulse on the destination register. Memory access uses two pulses: one loads the data register from memory, and one writes it back.

Decoding happens in two levels. The first level is a set of crosspoint terms. Each term is the AND of a subinstruction group and one time step. The second level ORs those terms into the final pulses, so a single crosspoint can fire several pulses and one pulse can have several sources. The add-to-storage step and the second half of a double-precision add use exactly the same terms. The common next-instruction fetch step has terms of its own. An ordinary instruction runs as an operation cycle followed by a fetch cycle. A jump runs as a fetch cycle alone. The subinstruction for a cycle is captured at the clock edge that leaves step 12.

Top module: `xpoint_pulse_gen`

## Requirements
- R1: After reset `step_o` reads 12. Each rising clock edge then moves it 12→1, 1→2, and so on up to 12, after which it wraps back to 1.
- R2: `sub_i` is captured only on the edge where `step_o` leaves 12. A change of `sub_i` at any other step has no effect on the pulses of the running cycle. The encoding is bit 0 = add-to-storage, bit 1 = second half of double add, bit 2 = instruction fetch.
- R3: If the captured `sub_i` has zero bits set or more than one bit set, the cycle is idle and `ctl_o` stays 0 for all twelve steps.
- R4: In an add-to-storage cycle, step 1 drives read-B (bit 0) and write-S (bit 1). Step 4 drives load-G-from-memory (bit 2). Step 5 drives A-to-X (bit 3), read-G (bit 4) and write-Y (bit 5). Step 6 drives read-U (bit 6) and write-G (bit 7).
- R5: In the same cycle, step 8 drives read-Z (bit 8) and write-S (bit 1). Step 10 drives memory write-back (bit 9). Step 11 drives read-U (bit 6) and write-A (bit 10).
- R6: A double-add second-half cycle produces exactly the same pulses as an add-to-storage cycle at every step.
- R7: In a fetch cycle, step 4 drives load-G-from-memory (bit 2). Step 6 drives read-G (bit 4) and write-B (bit 11). Step 10 drives memory write-back (bit 9).
- R8: Every bit of `ctl_o` is 0 at every step not listed for it in R4, R5 and R7. `ctl_o` is all 0 while reset is held.
- R9: An active-low asynchronous reset taken in the middle of a cycle at once returns `step_o` to 12 and `ctl_o` to 0. The next cycle starts normally with the `sub_i` captured on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-step clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_i | input | 3 | One-hot subinstruction for the next memory cycle |
| step_o | output | 4 | Current time step, 1 to 12 |
| ctl_o | output | 12 | Control pulses, bit map as in R4, R5, R7 |

## Verification
The assertions check four things on every cycle. The counter must advance and wrap. The held subinstruction must stay constant away from step 12. An idle or non-one-hot cycle must stay silent. Selected pulses must never appear outside their own step. The exact set of pulses at each step can only be shown by the bench scenarios. These are per-subinstruction tables walked over back-to-back sequences. The same applies to the identity of double-add and add. It also applies to the immunity to mid-cycle input changes and to recovery from a reset taken inside a cycle.

// File: rtl/xpoint_pulse_gen.sv
module xpoint_pulse_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  sub_i,
  output logic [3:0]  step_o,
  output logic [11:0] ctl_o
);
  localparam int NSTEP = 12;
  localparam logic [3:0] LAST = 4'(NSTEP);

  logic [3:0]       step_q;
  logic [2:0]       cur_q;
  logic [NSTEP:1]   t;
  logic             legal;

  assign legal = (sub_i != 3'd0) && ((sub_i & (sub_i - 3'd1)) == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= LAST;
      cur_q  <= 3'd0;
    end else if (step_q == LAST) begin
      step_q <= 4'd1;
      cur_q  <= legal ? sub_i : 3'd0;
    end else begin
      step_q <= step_q + 4'd1;
    end
  end

  for (genvar i = 1; i <= NSTEP; i++) begin : g_step
    assign t[i] = (step_q == 4'(i));
  end

  logic add_grp, fetch;
  assign add_grp = cur_q[0] | cur_q[1];
  assign fetch   = cur_q[2];

  logic xp1, xp4, xp5a, xp5b, xp6, xp8, xp10, xp11;
  logic fx4, fx6, fx10;
  assign xp1  = add_grp & t[1];
  assign xp4  = add_grp & t[4];
  assign xp5a = add_grp & t[5];
  assign xp5b = add_grp & t[5];
  assign xp6  = add_grp & t[6];
  assign xp8  = add_grp & t[8];
  assign xp10 = add_grp & t[10];
  assign xp11 = add_grp & t[11];
  assign fx4  = fetch & t[4];
  assign fx6  = fetch & t[6];
  assign fx10 = fetch & t[10];

  assign ctl_o[0]  = xp1;
  assign ctl_o[1]  = xp1 | xp8;
  assign ctl_o[2]  = xp4 | fx4;
  assign ctl_o[3]  = xp5a;
  assign ctl_o[4]  = xp5a | fx6;
  assign ctl_o[5]  = xp5b;
  assign ctl_o[6]  = xp6 | xp11;
  assign ctl_o[7]  = xp6;
  assign ctl_o[8]  = xp8;
  assign ctl_o[9]  = xp10 | fx10;
  assign ctl_o[10] = xp11;
  assign ctl_o[11] = fx6;

  assign step_o = step_q;

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != LAST) |=> (step_o == $past(step_o) + 4'd1)); // R1
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == LAST) |=> (step_o == 4'd1)); // R1
  AST_SUB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != LAST) |=> $stable(cur_q)); // R2
  AST_SUB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cur_q)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == 3'd0) |-> (ctl_o == 12'd0)); // R3
  AST_A2X_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[3] |-> (step_o == 4'd5)); // R8
  AST_WRBACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[9] |-> (step_o == 4'd10)); // R8
  AST_WRS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[1] |-> (step_o == 4'd1 || step_o == 4'd8)); // R8
  AST_FETCH_NO_A: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[11] |-> (ctl_o[10:5] == 6'd0)); // R7
endmodule

// File: tb/tb_xpoint_pulse_gen.sv
module tb_xpoint_pulse_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sub_i = 3'd0;
  logic [3:0] step_o;
  logic [11:0] ctl_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  xpoint_pulse_gen dut (.clk(clk), .rst_n(rst_n), .sub_i(sub_i), .step_o(step_o), .ctl_o(ctl_o));

  always #5 clk = ~clk;

  // rows: 0 add-to-storage, 1 double-add second half, 2 fetch; column = step-1
  localparam logic [11:0] EXP [0:35] = '{
    12'h003, 12'h000, 12'h000, 12'h004, 12'h038, 12'h0C0,
    12'h000, 12'h102, 12'h000, 12'h200, 12'h440, 12'h000,
    12'h003, 12'h000, 12'h000, 12'h004, 12'h038, 12'h0C0,
    12'h000, 12'h102, 12'h000, 12'h200, 12'h440, 12'h000,
    12'h000, 12'h000, 12'h000, 12'h004, 12'h000, 12'h810,
    12'h000, 12'h000, 12'h000, 12'h200, 12'h000, 12'h000 };

  localparam logic [2:0] SEQ [0:9] = '{
    3'b001, 3'b100, 3'b010, 3'b100, 3'b100,
    3'b000, 3'b011, 3'b111, 3'b100, 3'b001 };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int row_of(input logic [2:0] c);
    case (c)
      3'b001: return 0;
      3'b010: return 1;
      3'b100: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic string req_of(input int row, input int s);
    if (row < 0) return "R3";
    if (row == 1) return "R6";
    if (row == 2) return "R7";
    return (s <= 6) ? "R4" : "R5";
  endfunction

  // called at a negedge with step_o == 12
  task automatic run_mcycle(input logic [2:0] code, input bit scramble);
    int row = row_of(code);
    sub_i = code;
    for (int s = 1; s <= 12; s++) begin
      @(negedge clk);
      check(step_o == 4'(s), "R1", step_o, s);
      begin
        logic [11:0] e = (row < 0) ? 12'h000 : EXP[row*12 + s - 1];
        check(ctl_o == e, scramble ? "R2" : req_of(row, s), ctl_o, e);
        if (e == 12'h000) check(ctl_o == 12'h000, "R8", ctl_o, 0);
      end
      if (scramble && s == 2) sub_i = ~code;
      if (s == 11) sub_i = code;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(step_o == 4'd12, "R1", step_o, 12);
    check(ctl_o == 12'h000, "R8", ctl_o, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 10; k++) run_mcycle(SEQ[k], 1'b0);
    run_mcycle(3'b001, 1'b1);
    run_mcycle(3'b100, 1'b1);
    sub_i = 3'b001;
    repeat (5) @(negedge clk);
    check(step_o == 4'd5, "R9", step_o, 5);
    rst_n = 1'b0;
    #1;
    check(step_o == 4'd12, "R9", step_o, 12);
    check(ctl_o == 12'h000, "R9", ctl_o, 0);
    @(negedge clk);
    check(ctl_o == 12'h000, "R8", ctl_o, 0);
    rst_n = 1'b1;
    run_mcycle(3'b010, 1'b0);
    run_mcycle(3'b000, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", step_o, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule